// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block drives the column side of a synchronous DRAM burst. A start request presents the first column of the burst together with a length code, an ordering choice (linear or XOR) and a read/write flag. From the following clock onward the block emits one column address per cycle and flags the final address of a finite burst. It stops by itself at the end of a finite burst, on an explicit stop, or when a fresh start replaces the running burst.

Finite bursts stay inside an aligned window of 1, 2, 4 or 8 columns. Only the low bits of the address move inside that window, either by counting up with wrap or by XOR with the beat number. A page-length burst walks the whole 256-column row without end. An optional mode keeps reads at the programmed length but cuts every write to a single column.

The configuration is captured at the start request. Changes on those inputs while a burst runs do not reach the address stream.

Top module: `burst_col_seq`

## Requirements
- R1: A start request sampled at clock edge k makes `col_valid` high after edge k+1, and `col_out` then equals the `start_col` sampled at edge k.
- R2: With `interleave`=0 and a finite length L, beat n carries the start column with its low log2(L) bits replaced by (low bits + n) mod L. The upper bits stay fixed.
- R3: With `interleave`=1 and a finite length L, beat n carries the start column with its low log2(L) bits replaced by (low bits XOR n).
- R4: `len_code` 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Code 7 selects page length. Codes 4, 5 and 6 give a single beat.
- R5: A page-length burst outputs (start + n) mod 256 on beat n and ignores `interleave`. It never raises `last_beat` and runs until a stop or a new start.
- R6: `last_beat` is high only on the final beat of a finite burst. `col_valid` is low in the next cycle unless a start was sampled with that beat.
- R7: With `single_wr_mode`=1, a burst started with `is_write`=1 has exactly one beat, whatever the length code. A read still uses the programmed length. With `single_wr_mode`=0, writes use the programmed length.
- R8: A `stop` sampled during a burst makes `col_valid` low in the next cycle. When `start` is sampled in the same cycle, `start` wins.
- R9: A start request during an active burst abandons it. The next cycle carries beat 0 of the new burst.
- R10: After reset `col_valid` and `last_beat` are low until a start request.
- R11: Changes on `start_col`, `len_code`, `interleave`, `is_write` and `single_wr_mode` while `start` is low do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst with the presented configuration |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length code (see R4) |
| interleave | input | 1 | 1 selects XOR ordering, 0 selects linear ordering |
| is_write | input | 1 | 1 marks the burst as a write |
| single_wr_mode | input | 1 | 1 limits write bursts to one beat |
| stop | input | 1 | Terminate the running burst |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | High while a beat is being output |
| last_beat | output | 1 | High on the final beat of a finite burst |

## Verification
The hardest case to reach from the ports is the 255-to-0 rollover of a page-length burst. The same burst must also show that it never terminates on its own and never raises a last-beat flag. The bench starts a page burst at column 0xF3 with XOR ordering requested and follows it for 300 beats, past the rollover, before stopping it. Mid-burst restarts and stop/start collisions are placed on chosen beats by counting negedges after the launch. Every configuration input is scrambled right after each launch, so every sweep also checks that the settings are latched.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;
  // Length codes: the encoding is decoded by the configuration stage.
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  localparam int LEN_CODE_W = 3;
endpackage

// File: rtl/col_seq_cfg.sv
module col_seq_cfg
  import col_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  interleave,
  input  logic                  is_write,
  input  logic                  single_wr_mode,
  output logic [COL_W-1:0]      base_q,
  output logic [COL_W-1:0]      mask_q,
  output logic                  ilv_q,
  output logic                  page_q
);
  // Window mask: ones on the address bits that move inside the burst.
  function automatic logic [COL_W-1:0] f_window_mask(input logic [LEN_CODE_W-1:0] code);
    logic [COL_W-1:0] m;
    m = '0;
    case (len_code_e'(code))
      LEN_2:    m[0]   = 1'b1;
      LEN_4:    m[1:0] = 2'b11;
      LEN_8:    m[2:0] = 3'b111;
      LEN_PAGE: m      = '1;
      default:  m      = '0;
    endcase
    return m;
  endfunction

  logic wr_single;
  logic page_d;
  logic [COL_W-1:0] mask_d;

  assign wr_single = single_wr_mode & is_write;
  assign page_d    = (len_code_e'(len_code) == LEN_PAGE) & ~wr_single;
  assign mask_d    = wr_single ? '0 : f_window_mask(len_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      page_q <= 1'b0;
    end else if (load) begin
      base_q <= start_col;
      mask_q <= mask_d;
      ilv_q  <= interleave & ~page_d;
      page_q <= page_d;
    end
  end

  // R11: the latched settings move only on a load.
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q) && $stable(mask_q) && $stable(ilv_q) && $stable(page_q));
  // R5: page length always has the full mask and linear order.
  p_page_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    page_q |-> (mask_q == '1) && !ilv_q);
endmodule

// File: rtl/col_seq_beat.sv
module col_seq_beat #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic             page,
  input  logic [COL_W-1:0] mask,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic             last
);
  logic ev_stop;
  logic ev_end;

  assign last    = active & ~page & (beat == mask);
  assign ev_stop = active & stop & ~load;
  assign ev_end  = last & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (load) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (active) begin
      if (ev_stop || ev_end) begin
        active <= 1'b0;
      end else begin
        beat <= beat + COL_W'(1);
      end
    end
  end

  p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active && (beat == '0));
  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !active);
  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> !active);
  p_page_no_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && page) |-> !last);
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> !active);
endmodule

// File: rtl/col_seq_addr.sv
module col_seq_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  // Linear order: count inside the window, keep bits above it.
  function automatic logic [COL_W-1:0] f_linear(input logic [COL_W-1:0] b,
                                                input logic [COL_W-1:0] n,
                                                input logic [COL_W-1:0] m);
    return (b & ~m) | ((b + n) & m);
  endfunction

  // XOR order: flip window bits by the beat number.
  function automatic logic [COL_W-1:0] f_xor(input logic [COL_W-1:0] b,
                                             input logic [COL_W-1:0] n,
                                             input logic [COL_W-1:0] m);
    return (b & ~m) | ((b ^ n) & m);
  endfunction

  assign col = ilv ? f_xor(base, beat, mask) : f_linear(base, beat, mask);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import col_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  interleave,
  input  logic                  is_write,
  input  logic                  single_wr_mode,
  input  logic                  stop,
  output logic [COL_W-1:0]      col_out,
  output logic                  col_valid,
  output logic                  last_beat
);
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             page_q;
  logic             active;
  logic [COL_W-1:0] beat;
  logic             last;

  col_seq_cfg #(.COL_W(COL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(start),
    .start_col(start_col), .len_code(len_code), .interleave(interleave),
    .is_write(is_write), .single_wr_mode(single_wr_mode),
    .base_q(base_q), .mask_q(mask_q), .ilv_q(ilv_q), .page_q(page_q)
  );

  col_seq_beat #(.COL_W(COL_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(start), .stop(stop),
    .page(page_q), .mask(mask_q),
    .active(active), .beat(beat), .last(last)
  );

  col_seq_addr #(.COL_W(COL_W)) u_addr (
    .base(base_q), .beat(beat), .mask(mask_q), .ilv(ilv_q), .col(col_out)
  );

  assign col_valid = active;
  assign last_beat = last;

  p_first_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && (col_out == $past(start_col)));
  p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid) && !$past(start)) |->
      (((col_out ^ $past(col_out)) & ~mask_q) == '0));
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && col_valid) |=> col_valid && !$stable(beat) || (beat == '0));
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       interleave = 1'b0;
  logic       is_write = 1'b0;
  logic       single_wr_mode = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col_out;
  logic       col_valid;
  logic       last_beat;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .is_write(is_write),
    .single_wr_mode(single_wr_mode), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .last_beat(last_beat)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 means page length.
  function automatic int exp_len(input int code, input bit wr, input bit swm);
    if (swm && wr) return 1;
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int st, input int n, input int len, input bit ilv);
    int lo;
    if (len == 0) return (st + n) % 256;
    lo = st % len;
    if (ilv) return (st - lo) + (lo ^ n);
    return (st - lo) + ((lo + n) % len);
  endfunction

  task automatic launch(input int st, input int code, input bit ilv, input bit wr, input bit swm);
    @(negedge clk);
    start = 1'b1; start_col = 8'(st); len_code = 3'(code);
    interleave = ilv; is_write = wr; single_wr_mode = swm;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble every setting after the launch
    start_col = 8'(st) ^ 8'hA5; len_code = 3'(code) ^ 3'b101;
    interleave = ~ilv; is_write = ~wr; single_wr_mode = ~swm;
  endtask

  task automatic run_finite(input int st, input int code, input bit ilv,
                            input bit wr, input bit swm, input string req);
    int len;
    len = exp_len(code, wr, swm);
    launch(st, code, ilv, wr, swm);
    for (int n = 0; n < len; n++) begin
      chk({req, " valid R1"}, int'(col_valid), 1);
      chk({req, " col R11"}, int'(col_out), exp_col(st, n, len, ilv));
      chk({req, " last R6"}, int'(last_beat), (n == len - 1) ? 1 : 0);
      if (n < len - 1) @(negedge clk);
    end
    @(negedge clk);
    chk({req, " end R6"}, int'(col_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid", int'(col_valid), 0);
    chk("R10 last", int'(last_beat), 0);

    // R2 R3 R4: sweep codes, orders, starts
    for (int c = 0; c < 7; c++) begin
      for (int ilv = 0; ilv < 2; ilv++) begin
        for (int s = 0; s < 20; s++) begin
          int st;
          st = (s < 16) ? s : 236 + s;
          run_finite(st, c, 1'(ilv), 1'b0, 1'b0, ilv ? "R3 R4" : "R2 R4");
        end
      end
    end
    run_finite(8'h9D, 3, 1'b1, 1'b0, 1'b0, "R3");
    run_finite(8'h9D, 3, 1'b0, 1'b0, 1'b0, "R2");

    // R7: single-write mode
    run_finite(8'h36, 3, 1'b0, 1'b1, 1'b1, "R7 wr");
    run_finite(8'h36, 7, 1'b0, 1'b1, 1'b1, "R7 wr page");
    run_finite(8'h36, 3, 1'b1, 1'b0, 1'b1, "R7 rd");
    run_finite(8'h36, 2, 1'b0, 1'b1, 1'b0, "R7 off");

    // R5: page length, XOR requested but ignored, rollover, no end
    launch(8'hF3, 7, 1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 300; n++) begin
      chk("R5 col", int'(col_out), (8'hF3 + n) % 256);
      chk("R5 last", int'(last_beat), 0);
      chk("R5 valid", int'(col_valid), 1);
      if (n < 299) @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 page stop", int'(col_valid), 0);

    // R8: stop in a finite burst
    launch(8'h20, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R8 pre", int'(col_out), 8'h22);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stopped", int'(col_valid), 0);
    chk("R8 last", int'(last_beat), 0);

    // R9: restart mid-burst
    launch(8'h10, 3, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 pre", int'(col_out), 8'h13);
    start = 1'b1; start_col = 8'h47; len_code = 3'd2; interleave = 1'b0;
    is_write = 1'b0; single_wr_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 4; n++) begin
      chk("R9 valid", int'(col_valid), 1);
      chk("R9 col", int'(col_out), exp_col(8'h47, n, 4, 1'b0));
      chk("R9 last", int'(last_beat), (n == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9 end", int'(col_valid), 0);

    // R8: start and stop together, start wins
    launch(8'h80, 3, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; stop = 1'b1; start_col = 8'h5A; len_code = 3'd1;
    interleave = 1'b0; is_write = 1'b0; single_wr_mode = 1'b0;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk("R8 start wins valid", int'(col_valid), 1);
    chk("R8 start wins col", int'(col_out), 8'h5A);
    @(negedge clk);
    chk("R8 second col", int'(col_out), 8'h5B);
    chk("R8 second last", int'(last_beat), 1);

    // R9: restart on the last beat keeps running
    launch(8'h04, 1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; start_col = 8'hC1; len_code = 3'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R9 on last col", int'(col_out), 8'hC1);
    chk("R9 on last flag", int'(last_beat), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule